// File: doc/BRIEF.md
# Serial Bit Clock Mode Detector and Generator

This block sits at the front of a stereo audio sample input. It watches a dual-use pin that can carry either an external serial bit clock or a static de-emphasis select level, and it decides by itself which role the pin has. When no external bit clock is present, it makes a bit clock from the master clock. That clock stays phase-locked to the left/right frame clock. The block also hands the downstream filter a two-bit de-emphasis code. In internal mode both select pins form that code. In external mode only one select pin is meaningful.

All inputs are brought into the master clock domain through a synchronizer first. Mode detection counts rising edges of the synchronized pin. It enters external mode after a burst of edges inside a single frame-clock phase, and it leaves external mode after a run of quiet frame periods. The internal bit clock comes from a divider that restarts at every frame-clock transition. Its rate is picked by the interface format code and the master-to-frame clock ratio code.

Top module: `sclk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `ext_mode` is 0, `deemph_sel` is 00 and `bit_clk` is 0.
- R2: When EDGE_THRESH (default 16) rising edges of the dual-use pin arrive inside one frame-clock phase, `ext_mode` becomes 1. A rising edge that coincides with the phase change counts toward the new phase.
- R3: With at most EDGE_THRESH-1 rising edges in every phase, `ext_mode` stays 0.
- R4: In external mode, `ext_mode` returns to 0 at the frame-clock rising edge that closes the IDLE_PERIODS-th (default 2) consecutive frame period with no pin rising edge. It does not return earlier.
- R5: In internal mode the bit clock makes this many rising edges per frame period. For ratio code 1 (192x) or 3 (384x), every format gives 48. For ratio codes 0 (128x), 2 (256x) and 4 (512x), format codes 1 (left-justified) and 2 (24-bit right-justified) give 64, and format codes 0 (I2S 16-bit) and 3 (16-bit right-justified) give 32.
- R6: The internal bit clock is high for exactly half the master clock cycles of each frame period.
- R7: After every frame-clock transition the internal bit clock is driven low and rises one half bit period later. With the default two synchronizer stages and a registered output, `bit_clk` is low from the 4th to the (3+half)th master clock after the transition and high after that.
- R8: In internal mode, `deemph_sel` = {pin level, `dem0_in`}, with codes 00 off, 01 44.1 kHz, 10 48 kHz, 11 32 kHz.
- R9: In external mode, `deemph_sel[1]` is 0 and `deemph_sel[0]` follows `dem0_in` (01 = 44.1 kHz, 00 = off), whatever the pin does.
- R10: In external mode, `bit_clk` reproduces the synchronized pin, one rising edge per pin rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Left/right frame clock |
| sclk_dem_in | input | 1 | Dual-use pin: external bit clock or high de-emphasis select bit |
| dem0_in | input | 1 | Low de-emphasis select bit |
| fmt_sel | input | 2 | Interface format code (0 I2S 16-bit, 1 left-justified, 2 right-justified 24-bit, 3 right-justified 16-bit) |
| ratio_sel | input | 3 | Master/frame ratio code (0 128x, 1 192x, 2 256x, 3 384x, 4 512x) |
| bit_clk | output | 1 | Selected serial bit clock |
| ext_mode | output | 1 | 1 when an external bit clock is detected |
| deemph_sel | output | 2 | De-emphasis selection code |

## Verification
The two functions that can land in the same master clock cycle are a pin rising edge and the restart of the phase edge counter on a frame-clock transition. That edge must go into the fresh phase and must not be dropped. The bench provokes this by starting the 16-edge entry burst and the external-clock burst at the very moment the frame clock toggles, so that both signals leave the synchronizer together. It then judges that `ext_mode` is raised after exactly 16 pulses and that all 20 later pulses appear on `bit_clk`. The second coincidence is the divider restart on a frame transition meeting the divider's own toggle point. This is judged by the exact rising-edge and high-cycle counts per frame period, and by the phase of `bit_clk` right after a transition.

// File: rtl/sclk_mode_pkg.sv
package sclk_mode_pkg;

   typedef enum logic [1:0] {
      FMT_I2S_16   = 2'd0,
      FMT_LEFT     = 2'd1,
      FMT_RIGHT_24 = 2'd2,
      FMT_RIGHT_16 = 2'd3
   } fmt_e;

   typedef enum logic [2:0] {
      RAT_128 = 3'd0,
      RAT_192 = 3'd1,
      RAT_256 = 3'd2,
      RAT_384 = 3'd3,
      RAT_512 = 3'd4
   } ratio_e;

   // master clocks per frame for a ratio code; unknown codes act as 256x
   function automatic int unsigned ratio_value(input logic [2:0] code);
      case (code)
         RAT_128: return 128;
         RAT_192: return 192;
         RAT_384: return 384;
         RAT_512: return 512;
         default: return 256;
      endcase
   endfunction

   // internal bit clocks per frame
   function automatic int unsigned bits_per_frame(input logic [1:0] fmt,
                                                  input logic [2:0] code);
      if (code == RAT_192 || code == RAT_384)
         return 48;
      else if (fmt == FMT_LEFT || fmt == FMT_RIGHT_24)
         return 64;
      else
         return 32;
   endfunction

   // master clocks per half bit period
   function automatic int unsigned half_period(input logic [1:0] fmt,
                                               input logic [2:0] code);
      return ratio_value(code) / (2 * bits_per_frame(fmt, code));
   endfunction

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 1) else $fatal(1, "STAGES must be at least 1");
      assert (WIDTH >= 1)  else $fatal(1, "WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sclk_mode_detect.sv
module sclk_mode_detect #(
   parameter int EDGE_THRESH  = 16,
   parameter int IDLE_PERIODS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_rise,
   input  logic lr_edge,
   input  logic lr_rise,
   output logic ext_mode
);

   localparam int CNT_W  = $clog2(EDGE_THRESH + 1);
   localparam int IDLE_W = (IDLE_PERIODS > 1) ? $clog2(IDLE_PERIODS) : 1;

   initial begin
      assert (EDGE_THRESH >= 2)  else $fatal(1, "EDGE_THRESH must be at least 2");
      assert (IDLE_PERIODS >= 1) else $fatal(1, "IDLE_PERIODS must be at least 1");
   end

   logic [CNT_W-1:0]  cnt_q, base_cnt, next_cnt;
   logic [IDLE_W-1:0] idle_q;
   logic              seen_q;
   logic              burst_hit;

   // a rise in the same cycle as the phase change belongs to the new phase
   always_comb begin
      base_cnt  = lr_edge ? '0 : cnt_q;
      next_cnt  = base_cnt + CNT_W'(pin_rise);
      burst_hit = (next_cnt == CNT_W'(EDGE_THRESH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_mode <= 1'b0;
         cnt_q    <= '0;
         idle_q   <= '0;
         seen_q   <= 1'b0;
      end else if (!ext_mode) begin
         idle_q <= '0;
         seen_q <= 1'b0;
         if (burst_hit) begin
            ext_mode <= 1'b1;
            cnt_q    <= '0;
         end else begin
            cnt_q <= next_cnt;
         end
      end else begin
         cnt_q <= '0;
         if (lr_rise) begin
            seen_q <= 1'b0;
            if (seen_q || pin_rise) begin
               idle_q <= '0;
            end else if (idle_q == IDLE_W'(IDLE_PERIODS - 1)) begin
               idle_q   <= '0;
               ext_mode <= 1'b0;
            end else begin
               idle_q <= idle_q + 1'b1;
            end
         end else if (pin_rise) begin
            seen_q <= 1'b1;
         end
      end
   end

   // R2
   enter_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode) |-> $past(pin_rise));

   // R3
   no_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && !pin_rise) |=> !ext_mode);

   // R4
   leave_on_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_mode) |-> $past(lr_rise));

   // R4
   stay_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && pin_rise) |=> ext_mode);

endmodule

// File: rtl/sclk_int_gen.sv
module sclk_int_gen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lr_edge,
   input  logic [DIV_W-1:0] half_len,
   output logic             int_clk
);

   initial begin
      assert (DIV_W >= 2) else $fatal(1, "DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last_cnt;

   assign last_cnt = (half_len == '0) ? '0 : half_len - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         int_clk <= 1'b0;
      end else if (lr_edge) begin
         cnt_q   <= '0;
         int_clk <= 1'b0;
      end else if (cnt_q >= last_cnt) begin
         cnt_q   <= '0;
         int_clk <= ~int_clk;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lr_edge |=> !int_clk);

   // R6
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lr_edge && cnt_q < last_cnt) |=> $stable(int_clk));

endmodule

// File: rtl/sclk_mode_ctrl.sv
module sclk_mode_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int EDGE_THRESH  = 16,
   parameter int IDLE_PERIODS = 2,
   parameter int DIV_W        = 4,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic       mclk,
   input  logic       rst_n,
   input  logic       lrck_in,
   input  logic       sclk_dem_in,
   input  logic       dem0_in,
   input  logic [1:0] fmt_sel,
   input  logic [2:0] ratio_sel,
   output logic       bit_clk,
   output logic       ext_mode,
   output logic [1:0] deemph_sel
);

   import sclk_mode_pkg::*;

   localparam int SYNC_W = 8;

   initial begin
      assert ((2 ** DIV_W) > 8) else $fatal(1, "DIV_W too small for largest half period");
   end

   logic [SYNC_W-1:0] raw_vec, sync_vec;
   logic       lr_s, pin_s, dem0_s;
   logic [1:0] fmt_s;
   logic [2:0] ratio_s;
   logic       lr_d, pin_d;
   logic       lr_edge, lr_rise, pin_rise;
   logic [DIV_W-1:0] half_len;
   logic       int_clk;
   logic       sel_clk;

   assign raw_vec = {lrck_in, sclk_dem_in, dem0_in, fmt_sel, ratio_sel};

   sclk_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (mclk),
      .rst_n(rst_n),
      .d    (raw_vec),
      .q    (sync_vec)
   );

   assign {lr_s, pin_s, dem0_s, fmt_s, ratio_s} = sync_vec;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d  <= 1'b0;
         pin_d <= 1'b0;
      end else begin
         lr_d  <= lr_s;
         pin_d <= pin_s;
      end
   end

   assign lr_edge  = lr_s ^ lr_d;
   assign lr_rise  = lr_s & ~lr_d;
   assign pin_rise = pin_s & ~pin_d;

   sclk_mode_detect #(.EDGE_THRESH(EDGE_THRESH), .IDLE_PERIODS(IDLE_PERIODS)) u_detect (
      .clk     (mclk),
      .rst_n   (rst_n),
      .pin_rise(pin_rise),
      .lr_edge (lr_edge),
      .lr_rise (lr_rise),
      .ext_mode(ext_mode)
   );

   assign half_len = DIV_W'(half_period(fmt_s, ratio_s));

   sclk_int_gen #(.DIV_W(DIV_W)) u_gen (
      .clk     (mclk),
      .rst_n   (rst_n),
      .lr_edge (lr_edge),
      .half_len(half_len),
      .int_clk (int_clk)
   );

   assign sel_clk = ext_mode ? pin_s : int_clk;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge mclk or negedge rst_n) begin
         if (!rst_n) bit_clk <= 1'b0;
         else        bit_clk <= sel_clk;
      end
   end else begin : g_out_comb
      assign bit_clk = sel_clk;
   end

   // pin is a select bit only while no external clock is seen
   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n)        deemph_sel <= 2'b00;
      else if (ext_mode) deemph_sel <= {1'b0, dem0_s};
      else               deemph_sel <= {pin_s, dem0_s};
   end

   // R9
   ext_no_dem1_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      ext_mode |=> (deemph_sel[1] == 1'b0));

   // R8
   int_dem_track_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      (!ext_mode && pin_s && dem0_s) |=> (deemph_sel == 2'b11));

endmodule

// File: tb/sim_sclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sclk_mode_ctrl;

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lrck = 1'b0;
   logic       pin = 1'b0;
   logic       dem0 = 1'b0;
   logic [1:0] fmt = 2'd1;
   logic [2:0] ratio = 3'd4;
   logic       bit_clk, ext_mode;
   logic [1:0] deemph;

   int checks = 0;
   int errors = 0;
   int lr_half = 256;

   string tag_q[$];
   int    val_q[$];

   sclk_mode_ctrl u0 (
      .mclk       (mclk),
      .rst_n      (rst_n),
      .lrck_in    (lrck),
      .sclk_dem_in(pin),
      .dem0_in    (dem0),
      .fmt_sel    (fmt),
      .ratio_sel  (ratio),
      .bit_clk    (bit_clk),
      .ext_mode   (ext_mode),
      .deemph_sel (deemph)
   );

   always #2 mclk = ~mclk;

   initial forever begin
      repeat (lr_half) @(negedge mclk);
      lrck = ~lrck;
   end

   function automatic int rat_val(input int c);
      case (c)
         0: return 128;
         1: return 192;
         3: return 384;
         4: return 512;
         default: return 256;
      endcase
   endfunction

   function automatic int exp_bits(input int f, input int c);
      if (c == 1 || c == 3) return 48;
      if (f == 1 || f == 2) return 64;
      return 32;
   endfunction

   // driver side of the scoreboard
   task automatic push_exp(input string tag, input int v);
      tag_q.push_back(tag);
      val_q.push_back(v);
   endtask

   // monitor side of the scoreboard
   task automatic observe(input int act);
      string t;
      int    e;
      t = tag_q.pop_front();
      e = val_q.pop_front();
      checks++;
      if (act != e) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", t, act, e);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         pin = 1'b1;
         repeat (3) @(negedge mclk);
         pin = 1'b0;
         repeat (3) @(negedge mclk);
      end
   endtask

   task automatic set_cfg(input int f, input int c);
      fmt     = 2'(f);
      ratio   = 3'(c);
      lr_half = rat_val(c) / 2;
      repeat (3) @(posedge lrck);
   endtask

   task automatic measure_period(output int rises, output int highs);
      logic prev;
      rises = 0;
      highs = 0;
      @(posedge lrck);
      repeat (10) @(negedge mclk);
      prev = bit_clk;
      for (int i = 0; i < 2 * lr_half; i++) begin
         @(negedge mclk);
         if (bit_clk && !prev) rises++;
         if (bit_clk) highs++;
         prev = bit_clk;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge mclk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int rs, hs, bad, cnt;
      int cfg_f[7] = '{1, 0, 3, 2, 1, 0, 3};
      int cfg_c[7] = '{4, 2, 0, 0, 3, 1, 4};

      // R1 reset state
      repeat (20) @(negedge mclk);
      push_exp("R1 ext_mode in reset", 0);   observe(int'(ext_mode));
      push_exp("R1 deemph_sel in reset", 0); observe(int'(deemph));
      push_exp("R1 bit_clk in reset", 0);    observe(int'(bit_clk));
      rst_n = 1'b1;
      set_cfg(1, 4);

      // R8 internal de-emphasis from both pins
      for (int k = 0; k < 4; k++) begin
         pin  = k[1];
         dem0 = k[0];
         repeat (8) @(negedge mclk);
         push_exp($sformatf("R8 deemph pin=%0d dem0=%0d", k[1], k[0]), k);
         observe(int'(deemph));
      end
      pin  = 1'b0;
      dem0 = 1'b0;

      // R5 and R6 internal clock rate and duty
      for (int j = 0; j < 7; j++) begin
         set_cfg(cfg_f[j], cfg_c[j]);
         measure_period(rs, hs);
         push_exp($sformatf("R5 rises fmt=%0d ratio=%0d", cfg_f[j], cfg_c[j]),
                  exp_bits(cfg_f[j], cfg_c[j]));
         observe(rs);
         push_exp($sformatf("R6 high cycles fmt=%0d ratio=%0d", cfg_f[j], cfg_c[j]),
                  rat_val(cfg_c[j]) / 2);
         observe(hs);
      end

      // R7 phase after a frame transition (512x, left-justified, half = 4)
      set_cfg(1, 4);
      @(posedge lrck);
      repeat (5) @(negedge mclk);
      push_exp("R7 bit_clk low after transition", 0);   observe(int'(bit_clk));
      repeat (3) @(negedge mclk);
      push_exp("R7 bit_clk high half bit later", 1);    observe(int'(bit_clk));

      // R3 fifteen edges per phase keep internal mode
      for (int p = 0; p < 4; p++) begin
         @(lrck);
         repeat (5) @(negedge mclk);
         pulses(15);
      end
      repeat (8) @(negedge mclk);
      push_exp("R3 ext_mode after 15 edges per phase", 0); observe(int'(ext_mode));

      // R2 sixteen edges starting with the phase change
      @(lrck);
      pulses(16);
      repeat (8) @(negedge mclk);
      push_exp("R2 ext_mode after 16 edges", 1);           observe(int'(ext_mode));

      // R10 and R9 external clock pass-through and de-emphasis
      dem0 = 1'b1;
      repeat (8) @(negedge mclk);
      @(posedge lrck);
      rs  = 0;
      bad = 0;
      fork
         pulses(20);
         begin
            logic prev;
            prev = bit_clk;
            for (int i = 0; i < 150; i++) begin
               @(negedge mclk);
               if (bit_clk && !prev) rs++;
               if (deemph != 2'b01) bad++;
               prev = bit_clk;
            end
         end
      join
      push_exp("R10 bit_clk rises for 20 pin rises", 20); observe(rs);
      push_exp("R9 cycles with deemph not 01", 0);       observe(bad);

      // R4 two quiet frame periods
      @(posedge lrck);
      @(posedge lrck);
      repeat (10) @(negedge mclk);
      cnt = int'(ext_mode);
      push_exp("R4 ext_mode after one quiet period", 1);  observe(cnt);
      @(posedge lrck);
      repeat (10) @(negedge mclk);
      push_exp("R4 ext_mode after two quiet periods", 0); observe(int'(ext_mode));
      push_exp("R8 deemph back in internal mode", 1);     observe(int'(deemph));

      finish_run();
   end

endmodule